// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Streamer

This block holds a small configuration image and plays it out to a downstream programmable device, one step per rising edge of an externally supplied configuration clock. In serial mode each stored byte leaves most significant bit first on data pin 0. In parallel mode a whole byte leaves on data pins 0 to 7 each clock. A control bit picks the mode, and serial is the default.

The stream runs only while the active-low chip enable is low and the shared active-low output-enable/reset line is high. Dropping either one clears the read position, so the next stream starts again at the first byte. After the last stored item has been sent, the next clock edge releases the data pins and pulls the active-low cascade output low. That output drives the chip enable of a second memory that shares the clock and data wires, so the stream carries on without a gap. A power-on counter clocked by a free-running clock holds the output-enable/reset line low until the supply-good input has stayed high for a fixed number of cycles. The counter pulls the line low again as soon as supply-good falls. The line is wire-ANDed outside the block and is always active-low. The image and the mode bit are loaded through a simple write port that a testbench uses.

Top module: `cfg_stream_rom`

## Requirements
- R1: The data pins are released (enable vector 0) and the cascade output is high whenever the output-enable/reset line is low, even with chip enable low.
- R2: When streaming begins, the first item (byte 0, bit 7 in serial mode) is presented before any clock edge. Every rising configuration clock edge then advances the read position by one item.
- R3: In serial mode only pin 0 is enabled (enable vector 8'h01). Bits of each byte appear most significant first, bytes in ascending address order.
- R4: In parallel mode all eight pins are enabled (enable vector 8'hFF) and one stored byte is presented per clock, in ascending address order.
- R5: Serial mode is in force until a control write with bit value 1 selects parallel. A control write with value 0 returns to serial.
- R6: On the clock edge after the last item of the LEN-byte image, the cascade output goes low and all data pins are released. This state lasts through further clocks until streaming is stopped.
- R7: Stopping the stream part-way (chip enable high or output-enable/reset low) clears the read position, and the next stream restarts at byte 0, bit 7.
- R8: While supply-good is low the block holds the output-enable/reset line low. After supply-good rises, the line is released on the POR_DELAY-th rising edge of the reset clock and not earlier. A later fall of supply-good pulls it low again at once.
- R9: With chip enable high the block is in standby. Pins are released, the cascade output is high, and the read position does not move, whether output-enable is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock; read position steps on its rising edge |
| rclk | input | 1 | Free-running clock for the power-on hold counter |
| supply_ok | input | 1 | High while the supply is above its good threshold |
| ce_n | input | 1 | Active-low chip enable |
| oe_line | input | 1 | Level of the shared active-low output-enable/reset line |
| hold_rel | output | 1 | 0 pulls the output-enable/reset line low, 1 releases it |
| wr_en | input | 1 | Write one image byte on the rising cclk edge |
| wr_addr | input | AW | Image byte address |
| wr_data | input | 8 | Image byte value |
| mode_we | input | 1 | Write the mode bit on the rising cclk edge |
| mode_par | input | 1 | Mode bit value: 1 parallel, 0 serial |
| dout | output | 8 | Data value, meaningful on enabled pins |
| dout_en | output | 8 | Per-pin drive enable; 0 means high-impedance |
| ceo_n | output | 1 | Active-low cascade enable to the next memory |

## Verification
The clocked properties assume that chip enable and the output-enable/reset line change away from the rising configuration clock edge. They also assume that supply-good changes away from the reset clock edge, and that the mode bit is not rewritten during a stream. The bench drives every control input just after a falling edge of the matching clock. It writes the mode bit only while chip enable is high. It samples one time unit after that falling edge, so each sample sees the position reached after the preceding rising edge.

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom #(
  parameter int DEPTH     = 64,
  parameter int LEN       = 48,
  parameter int POR_DELAY = 20,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(POR_DELAY + 1)
) (
  input  logic          cclk,
  input  logic          rclk,
  input  logic          supply_ok,
  input  logic          ce_n,
  input  logic          oe_line,
  output logic          hold_rel,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          mode_we,
  input  logic          mode_par,
  output logic [7:0]    dout,
  output logic [7:0]    dout_en,
  output logic          ceo_n
);

  localparam logic [AW-1:0] LAST = AW'(LEN - 1);

  logic [7:0]    mem [DEPTH];
  logic          par_sel = 1'b0;
  logic [AW-1:0] addr;
  logic [2:0]    bitc;
  logic          done;
  logic [CW-1:0] por_cnt;
  logic          idle;

  assign hold_rel = (por_cnt == CW'(POR_DELAY));
  assign idle     = ce_n | ~oe_line | ~hold_rel;

  always_ff @(posedge rclk or negedge supply_ok)
    if (!supply_ok)     por_cnt <= '0;
    else if (!hold_rel) por_cnt <= por_cnt + 1'b1;

  always_ff @(posedge cclk) begin
    if (wr_en)   mem[wr_addr] <= wr_data;
    if (mode_we) par_sel <= mode_par;
  end

  always_ff @(posedge cclk or posedge idle)
    if (idle) begin
      addr <= '0;
      bitc <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (par_sel || bitc == 3'd7) begin
        bitc <= '0;
        if (addr == LAST) done <= 1'b1;
        else              addr <= addr + 1'b1;
      end else begin
        bitc <= bitc + 1'b1;
      end
    end

  wire       live = ~idle & ~done;
  wire [7:0] cur  = mem[addr];

  assign dout    = !live ? 8'h00 : par_sel ? cur : {7'b0, cur[3'd7 - bitc]};
  assign dout_en = !live ? 8'h00 : par_sel ? 8'hFF : 8'h01;
  assign ceo_n   = ~(done & ~idle);

  always_comb
    if (idle) p_released_when_idle_r1: assert (dout_en == 8'h00 && ceo_n);

  p_serial_one_pin_r3: assert property (@(posedge cclk) disable iff (idle)
    (!par_sel && dout_en != 8'h00) |-> dout_en == 8'h01);

  p_parallel_all_pins_r4: assert property (@(posedge cclk) disable iff (idle)
    (par_sel && dout_en != 8'h00) |-> dout_en == 8'hFF);

  p_addr_steps_r2: assert property (@(posedge cclk) disable iff (idle)
    (par_sel && !done && addr != LAST) |=> addr == $past(addr) + 1'b1);

  p_cascade_after_last_r6: assert property (@(posedge cclk) disable iff (idle)
    (!done && addr == LAST && (par_sel || bitc == 3'd7)) |=> (!ceo_n && dout_en == 8'h00));

  p_cascade_sticks_r6: assert property (@(posedge cclk) disable iff (idle)
    !ceo_n |=> !ceo_n);

  p_release_once_r8: assert property (@(posedge rclk) disable iff (!supply_ok)
    hold_rel |=> hold_rel);

  p_release_timing_r8: assert property (@(posedge rclk) disable iff (!supply_ok)
    $rose(hold_rel) |-> $past(por_cnt) == CW'(POR_DELAY - 1));

endmodule

// File: tb/tb_cfg_stream_rom.sv
module tb_cfg_stream_rom;
  localparam int PERIOD = 10;
  localparam int RPER   = 14;
  localparam int DEPTH  = 64;
  localparam int LEN    = 48;
  localparam int PD     = 20;
  localparam int AW     = $clog2(DEPTH);

  logic cclk = 0, rclk = 0;
  logic supply_ok = 0, ce_n = 1, ext_oe = 1;
  logic wr_en = 0, mode_we = 0, mode_par = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic hold_rel, ceo_n;
  logic [7:0] dout, dout_en;
  wire oe_line = hold_rel & ext_oe;

  int checks = 0, errors = 0;

  always #(PERIOD/2) cclk = ~cclk;
  always #(RPER/2) rclk = ~rclk;

  cfg_stream_rom #(.DEPTH(DEPTH), .LEN(LEN), .POR_DELAY(PD)) dut (
    .cclk, .rclk, .supply_ok, .ce_n, .oe_line, .hold_rel,
    .wr_en, .wr_addr, .wr_data, .mode_we, .mode_par,
    .dout, .dout_en, .ceo_n);

  function automatic logic [7:0] img(int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge cclk);
    #1;
  endtask

  task automatic t_reset;
    #2;
    chk("R8 held at reset", hold_rel, 0);
    chk("R1 pins released at reset", dout_en, 0);
    chk("R1 cascade high at reset", ceo_n, 1);
  endtask

  task automatic t_por;
    @(negedge rclk); supply_ok = 1;
    repeat (PD - 1) @(negedge rclk);
    #1 chk("R8 still held before delay", hold_rel, 0);
    @(negedge rclk); #1 chk("R8 released at delay", hold_rel, 1);
    supply_ok = 0; #1 chk("R8 pulled low on supply drop", hold_rel, 0);
    @(negedge rclk); supply_ok = 1;
    repeat (PD) @(negedge rclk);
    #1 chk("R8 released again", hold_rel, 1);
  endtask

  task automatic t_load;
    @(negedge cclk);
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1; wr_addr = AW'(i); wr_data = img(i);
      @(negedge cclk);
    end
    wr_en = 0;
  endtask

  task automatic t_standby;
    ce_n = 1; ext_oe = 1; step(5);
    chk("R9 standby oe high pins", dout_en, 0);
    chk("R9 standby oe high ceo", ceo_n, 1);
    ext_oe = 0; step(3);
    chk("R9 standby oe low pins", dout_en, 0);
    ext_oe = 1; step();
    ce_n = 0; #1;
    chk("R9 no advance in standby", dout[0], int'(img(0)[7]));
    ce_n = 1; step();
  endtask

  task automatic t_oe_low;
    ce_n = 0; ext_oe = 0; step(2);
    chk("R1 oe low releases pins", dout_en, 0);
    chk("R1 oe low cascade high", ceo_n, 1);
    ext_oe = 1; ce_n = 1; step();
  endtask

  task automatic t_serial;
    int bad = 0;
    ce_n = 0; #1;
    chk("R2 first bit before edge", dout[0], int'(img(0)[7]));
    for (int k = 0; k < LEN * 8; k++) begin
      if (dout_en != 8'h01 || dout[0] != img(k / 8)[7 - (k % 8)]) bad++;
      if (k == 9) chk("R3 serial msb-first bit 9", dout[0], int'(img(1)[6]));
      if (k == 0) chk("R3 serial pin 0 only", dout_en, 8'h01);
      step();
    end
    chk("R2 R3 serial stream mismatches", bad, 0);
    chk("R6 cascade low after last bit", ceo_n, 0);
    chk("R6 pins released after last bit", dout_en, 0);
    step(4);
    chk("R6 cascade stays low", ceo_n, 0);
    ce_n = 1; #1 chk("R6 cascade high when stopped", ceo_n, 1);
    step();
  endtask

  task automatic t_abort;
    ce_n = 0; step(21);
    chk("R7 mid-stream bit", dout[0], int'(img(2)[2]));
    ext_oe = 0; step();
    chk("R7 stopped pins released", dout_en, 0);
    ext_oe = 1; #1;
    chk("R7 restart at byte 0 bit 7", dout[0], int'(img(0)[7]));
    step();
    chk("R7 next is byte 0 bit 6", dout[0], int'(img(0)[6]));
    ce_n = 1; step();
  endtask

  task automatic t_parallel;
    int bad = 0;
    mode_we = 1; mode_par = 1; step(); mode_we = 0;
    ce_n = 0; #1;
    chk("R5 parallel selected", dout_en, 8'hFF);
    for (int i = 0; i < LEN; i++) begin
      if (dout_en != 8'hFF || dout != img(i)) bad++;
      if (i == 3) chk("R4 byte 3", dout, img(3));
      step();
    end
    chk("R4 parallel stream mismatches", bad, 0);
    chk("R6 parallel cascade low", ceo_n, 0);
    chk("R6 parallel pins released", dout_en, 0);
    ce_n = 1; step();
    mode_we = 1; mode_par = 0; step(); mode_we = 0;
    ce_n = 0; #1;
    chk("R5 back to serial", dout_en, 8'h01);
    ce_n = 1; step();
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_por();
    t_load();
    t_standby();
    t_oe_low();
    t_serial();
    t_abort();
    t_parallel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule